// File: doc/BRIEF.md
# Frame Activity Scanner

This block watches a binary activity map, one bit per pixel, and decides whether enough of the scene has changed to wake a processor. A single start pulse makes it scan every row of the map once. For each row it names the row it wants, takes the row's bits from the array over a valid/ready handshake, and then examines the columns one per clock, lowest index first. Every set bit adds one to a frame total. When the last column of a row has been examined it pulses an end-of-row strobe and only then asks for the next row. After the final row it pulses end-of-frame. At that point the total is compared with a threshold supplied by the user, and an alert flag is raised if the total has reached it.

The scanner produces no pixel stream and no addresses. The only things it reports are the frame total and the alert flag, which serves as a wake-up interrupt. The flag and the total both stay valid until the next accepted start. Back-pressure on the row interface runs one way. The scanner raises `row_ready_o` only while it is waiting for the row named on `row_sel_o`. A row is taken on the clock edge where `row_valid_i` and `row_ready_o` are both high. The array may hold `row_valid_i` low for any number of cycles, and while `row_ready_o` is low the scanner ignores `row_valid_i` and `row_bits_i`.

Top module: `frame_activity_scan`

## Requirements
- R1: A frame consists of exactly ROWS (default 64) end-of-row pulses. `eof_o` rises in the cycle after the last of them, and never earlier.
- R2: A `start_i` pulse sampled while the scanner is idle begins a frame. `row_ready_o` is high in the following cycle, and `eof_o` is high for exactly one cycle per frame.
- R3: Once a row has been accepted, the scanner examines bit c of `row_bits_i` as column c, in order c = 0, 1, …, COLS-1, one column per clock. `eor_o` is visible exactly COLS clock edges after the accepting edge.
- R4: `row_sel_o` is 0 for the first row and increases by one after each `eor_o`. It changes at no other time except an accepted start, and the next row is requested only after `eor_o`.
- R5: Each set bit of the map adds exactly one to `count_o`. The count is 13 bits wide by default, reaches 4096 for a fully active 64x64 map without wrapping, and never exceeds ROWS*COLS.
- R6: In the `eof_o` cycle, `flag_o` equals (`count_o` >= `thresh_i`). The flag rises only in that cycle and holds its value until the next accepted start.
- R7: An accepted start clears `count_o` and `flag_o`. Both read 0 in the cycle after the start is sampled.
- R8: A `start_i` pulse that arrives while a frame is in progress has no effect. The row sequence, the total and the flag come out as if it had not occurred.
- R9: A row is accepted only on an edge where both `row_valid_i` and `row_ready_o` are high. `row_ready_o` falls in the cycle after acceptance, and any number of cycles with `row_valid_i` low leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request; honoured only while idle |
| thresh_i | input | CNT_W (13) | Alert threshold on the active-pixel total |
| row_sel_o | output | ROW_W (6) | Index of the row currently wanted or being walked |
| row_ready_o | output | 1 | Scanner can take the selected row |
| row_valid_i | input | 1 | Array presents the selected row on `row_bits_i` |
| row_bits_i | input | COLS (64) | Activity bits of the row, bit c = column c |
| eor_o | output | 1 | One-cycle end-of-row strobe |
| eof_o | output | 1 | One-cycle end-of-frame strobe |
| count_o | output | CNT_W (13) | Active-pixel total of the current or last frame |
| flag_o | output | 1 | Alert: last frame total reached the threshold |

## Verification
Several properties are checked on every cycle. `eof_o` is a single-cycle pulse and arrives only after a full set of end-of-row strobes. The row index moves only on end-of-row or start. The total steps by at most one and never passes the map size. The flag rises only together with end-of-frame, and ready drops after each handshake. Other behaviour can only be shown by the bench's scenarios: the exact total for a given map, the order in which columns are visited, the threshold boundary (equal, one above, one below, zero), the clearing on a new start, and the indifference to a start that arrives mid-frame. These scenarios use several arithmetic activity patterns over the full 64x64 map and varied row-delivery delays.

// File: rtl/fas_pkg.sv
package fas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WALK,
    ST_EOR,
    ST_FIN
  } scan_st_t;
endpackage

// File: rtl/fas_scan_ctrl.sv
module fas_scan_ctrl
  import fas_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             row_valid_i,
  output logic [ROW_W-1:0] row_sel_o,
  output logic             row_ready_o,
  output logic             eor_o,
  output logic             eof_o,
  output logic             walk_o,
  output logic             load_o,
  output logic             clr_o,
  output logic             eval_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  scan_st_t         st_q, st_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             last_row, last_col;

  assign last_row = (row_q == LAST_ROW);
  assign last_col = (col_q == LAST_COL);

  // a start is honoured only from the idle state
  assign clr_o       = start_i && (st_q == ST_IDLE);
  assign row_ready_o = (st_q == ST_REQ);
  assign load_o      = row_ready_o && row_valid_i;
  assign walk_o      = (st_q == ST_WALK);
  assign eor_o       = (st_q == ST_EOR);
  assign eof_o       = (st_q == ST_FIN);
  assign eval_o      = eor_o && last_row;
  assign row_sel_o   = row_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)     st_d = ST_REQ;
      ST_REQ:  if (row_valid_i) st_d = ST_WALK;
      ST_WALK: if (last_col)    st_d = ST_EOR;
      ST_EOR:  st_d = last_row ? ST_FIN : ST_REQ;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
    end else begin
      st_q <= st_d;
      if (clr_o) row_q <= '0;
      else if (eor_o && !last_row) row_q <= row_q + 1'b1;
      if (load_o) col_q <= '0;
      else if (walk_o && !last_col) col_q <= col_q + 1'b1;
    end
  end
endmodule

// File: rtl/fas_col_walker.sv
module fas_col_walker #(
  parameter int COLS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            walk_i,
  input  logic [COLS-1:0] row_bits_i,
  output logic            pix_o
);
  logic [COLS-1:0] sh_q;

  // column 0 sits at bit 0 and is examined first; each walk cycle moves the
  // next column down into position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (load_i) sh_q <= row_bits_i;
    else if (walk_i) sh_q <= {1'b0, sh_q[COLS-1:1]};
  end

  assign pix_o = sh_q[0];
endmodule

// File: rtl/fas_act_counter.sv
module fas_act_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (inc_i)  cnt_q  <= cnt_q + 1'b1;
      if (eval_i) flag_q <= (cnt_q >= thresh_i);
    end
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/frame_activity_scan.sv
module frame_activity_scan #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int ROW_W = $clog2(ROWS),
  parameter int CNT_W = $clog2(ROWS * COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [ROW_W-1:0] row_sel_o,
  output logic             row_ready_o,
  input  logic             row_valid_i,
  input  logic [COLS-1:0]  row_bits_i,
  output logic             eor_o,
  output logic             eof_o,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  localparam int COL_W = $clog2(COLS);

  logic walk, load, clr, eval, pix;

  fas_scan_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_valid_i(row_valid_i),
    .row_sel_o(row_sel_o), .row_ready_o(row_ready_o), .eor_o(eor_o),
    .eof_o(eof_o), .walk_o(walk), .load_o(load), .clr_o(clr), .eval_o(eval)
  );

  fas_col_walker #(.COLS(COLS)) u_walk (
    .clk(clk), .rst_n(rst_n), .load_i(load), .walk_i(walk),
    .row_bits_i(row_bits_i), .pix_o(pix)
  );

  fas_act_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(walk && pix),
    .eval_i(eval), .thresh_i(thresh_i), .count_o(count_o), .flag_o(flag_o)
  );
endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int ROW_W = $clog2(ROWS),
  parameter int CNT_W = $clog2(ROWS * COLS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [ROW_W-1:0] row_sel_o,
  input logic             row_ready_o,
  input logic             row_valid_i,
  input logic             eor_o,
  input logic             eof_o,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o
);
  logic [ROW_W:0] eor_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     eor_seen <= '0;
    else if (eof_o) eor_seen <= '0;
    else if (eor_o) eor_seen <= eor_seen + 1'b1;
  end

  a_r1_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (eor_seen == (ROW_W+1)'(ROWS)));

  a_r2_eof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> !eof_o);

  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(eor_o && eof_o));

  a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eor_o && !start_i) |=> $stable(row_sel_o));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1) || (count_o == '0));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(ROWS * COLS));

  a_r6_flag_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> eof_o);

  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (row_ready_o && row_valid_i) |=> !row_ready_o);
endmodule

bind frame_activity_scan fas_checker #(
  .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_fas_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_sel_o(row_sel_o),
  .row_ready_o(row_ready_o), .row_valid_i(row_valid_i), .eor_o(eor_o),
  .eof_o(eof_o), .count_o(count_o), .flag_o(flag_o)
);

// File: tb/tb_frame_activity_scan.sv
module tb_frame_activity_scan;
  localparam int ROWS  = 64;
  localparam int COLS  = 64;
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = $clog2(ROWS * COLS + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] thresh_i = '0;
  logic [ROW_W-1:0] row_sel_o;
  logic             row_ready_o;
  logic             row_valid_i = 1'b0;
  logic [COLS-1:0]  row_bits_i = '0;
  logic             eor_o, eof_o, flag_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  frame_activity_scan #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .thresh_i(thresh_i),
    .row_sel_o(row_sel_o), .row_ready_o(row_ready_o), .row_valid_i(row_valid_i),
    .row_bits_i(row_bits_i), .eor_o(eor_o), .eof_o(eof_o),
    .count_o(count_o), .flag_o(flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pix(input int p, input int r, input int c);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return ((r + c) % 2) == 0;
      3: return ((r * 7 + c * 3) % 5) == 0;
      default: return (r == ROWS - 1) && (c == COLS - 1);
    endcase
  endfunction

  function automatic int total(input int p);
    int s = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) s += pix(p, r, c);
    return s;
  endfunction

  task automatic run_frame(input int p, input int thr, input bit mid_start);
    int base, n, exp_tot;
    bit ord_ok, tim_ok, seq_ok;
    exp_tot = total(p);
    thresh_i = CNT_W'(thr);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    // R7: start clears the total and the flag
    chk(count_o == 0, "R7 count cleared", int'(count_o), 0);
    chk(flag_o == 1'b0, "R7 flag cleared", int'(flag_o), 0);
    // R2: ready follows the accepted start
    chk(row_ready_o == 1'b1, "R2 ready after start", int'(row_ready_o), 1);
    base = 0; ord_ok = 1'b1; tim_ok = 1'b1; seq_ok = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      while (!row_ready_o) @(negedge clk);
      if (row_sel_o != ROW_W'(r)) seq_ok = 1'b0;
      repeat ((r * 3 + p) % 4) @(negedge clk);  // R9: delayed row delivery
      row_valid_i = 1'b1;
      for (int c = 0; c < COLS; c++) row_bits_i[c] = pix(p, r, c);
      @(negedge clk);
      row_valid_i = 1'b0;
      row_bits_i = '1;  // ignored after acceptance
      if (mid_start && r == 10) start_i = 1'b1;  // R8
      n = 0;
      do begin
        @(negedge clk);
        start_i = 1'b0;
        n++;
        begin
          int part = base;
          for (int c = 0; c < n && c < COLS; c++) part += pix(p, r, c);
          if (int'(count_o) != part) ord_ok = 1'b0;
        end
      end while (!eor_o && n < COLS + 8);
      if (n != COLS) tim_ok = 1'b0;
      if (eor_o && eof_o) tim_ok = 1'b0;
      for (int c = 0; c < COLS; c++) base += pix(p, r, c);
      if (r < ROWS - 1 && eof_o) tim_ok = 1'b0;
    end
    chk(seq_ok, "R4 row sequence", int'(seq_ok), 1);
    chk(ord_ok, "R3 column order", int'(ord_ok), 1);
    chk(tim_ok, "R3 eor timing", int'(tim_ok), 1);
    @(negedge clk);
    chk(eof_o == 1'b1, "R1 eof after last row", int'(eof_o), 1);
    chk(int'(count_o) == exp_tot, "R5 frame total", int'(count_o), exp_tot);
    chk(flag_o == (exp_tot >= thr), "R6 flag at eof", int'(flag_o), int'(exp_tot >= thr));
    @(negedge clk);
    chk(eof_o == 1'b0, "R2 eof single cycle", int'(eof_o), 0);
    repeat (3) @(negedge clk);
    chk(flag_o == (exp_tot >= thr), "R6 flag held", int'(flag_o), int'(exp_tot >= thr));
    chk(int'(count_o) == exp_tot, "R6 total held", int'(count_o), exp_tot);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(row_ready_o == 1'b0 && eor_o == 1'b0 && eof_o == 1'b0, "R2 reset idle",
        int'({row_ready_o, eor_o, eof_o}), 0);
    chk(count_o == 0 && flag_o == 1'b0, "R7 reset clear", int'(count_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(row_ready_o == 1'b0, "R2 no scan without start", int'(row_ready_o), 0);
    run_frame(0, 0, 1'b0);                 // zero total, zero threshold -> alert
    run_frame(1, ROWS * COLS, 1'b0);       // R5 full map, no wrap, equal threshold
    run_frame(2, total(2) + 1, 1'b0);      // one above total -> no alert
    run_frame(2, total(2), 1'b1);          // equal, with ignored mid-frame start (R8)
    run_frame(3, total(3) - 1, 1'b0);      // one below -> alert
    run_frame(4, 1, 1'b0);                 // single last pixel, R3 order
    run_frame(4, 2, 1'b0);
    run_frame(0, 1, 1'b0);                 // previous alert must not persist
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule